// File: doc/BRIEF.md
# Three-Lane First-Press Winner Latch

This block watches the finish pushbuttons of three race lanes and records which lane is pressed first. Each raw button line is first brought into the clock domain by a two-flop synchronizer. A counter then filters out contact bounce. Only after that does a four-state machine see the button.

Once a winner is recorded, the machine ignores every button until reset. The result appears on two outputs. One is a one-hot indicator per lane. The other is a two-bit code that equals the state register, together with a valid flag. If several lanes become pressed on the same clock while no winner exists, the lowest-numbered lane is chosen. A one-cycle tie pulse marks that case.

A user asserts the synchronous reset between races and reads the winner outputs at any time afterwards. With default parameters, a clean press is recorded seven clocks after the raw line rises: two synchronizer stages, four debounce clocks, and one state update.

Top module: `lane_first_latch`

## Requirements
- R1: While reset is sampled high on a rising clock edge, the machine enters idle. After that edge, `lane_won` = 000, `win_code` = 00, `win_valid` = 0 and `tie_pulse` = 0.
- R2: The winner code encodes idle as 00, lane 1 as 01, lane 2 as 10 and lane 3 as 11. `lane_won[0]`, `[1]` and `[2]` are high exactly for codes 01, 10 and 11. `win_valid` is high exactly when the code is not 00.
- R3: From idle, a clean press on one lane sets that lane as winner. With default parameters this happens on the 7th rising edge after the raw line rises, and not on the 6th. Without a press, idle holds.
- R4: In a winner state, presses and releases on any lane, the winning lane included, leave every output unchanged until reset.
- R5: When reset and a press take effect on the same clock edge, reset wins and the machine stays idle.
- R6: When two or more lanes become pressed on the same clock in idle, the lowest-numbered of them wins (lanes 2+3 give 10, lanes 1+2+3 give 01).
- R7: A tie as in R6 raises `tie_pulse` for exactly one clock, in the same cycle the winner first appears. A single-lane win leaves it low.
- R8: A raw level that stays high for fewer than DEBOUNCE_CYCLES (default 4) consecutive synchronized clocks is not a press, however often it repeats.
- R9: A button already debounced high when reset ends does not win. It must first be released and then pressed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_raw | input | 3 | Raw lane buttons, bit 0 = lane 1 |
| lane_won | output | 3 | One-hot winner indicator, bit 0 = lane 1 |
| win_code | output | 2 | Encoded winner, equal to the state register |
| win_valid | output | 1 | High when a winner is held |
| tie_pulse | output | 1 | One-clock pulse when simultaneous presses were resolved |

## Verification
Reset and a fresh press can land on the same clock edge. The bench provokes this by raising reset in exactly the cycle in which a debounced lane-2 press reaches the state machine. It then requires the machine to remain idle. Because the button is still held when reset drops, the same scenario also checks that the lane cannot win until it is released and pressed again. Simultaneous presses are provoked by raising two or three raw lines on the same clock. They are judged by the resulting code and by a tie pulse exactly one cycle wide.

// File: rtl/race_pkg.sv
package race_pkg;
    localparam int LANES   = 3;
    localparam int CODE_W  = 2;

    typedef enum logic [CODE_W-1:0] {
        ST_IDLE = 2'b00,
        ST_L1   = 2'b01,
        ST_L2   = 2'b10,
        ST_L3   = 2'b11
    } race_st_e;

    typedef struct packed {
        race_st_e         st;
        logic [LANES-1:0] arm;
        logic             tie;
    } fsm_regs_t;
endpackage

// File: rtl/lane_sync.sv
module lane_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/lane_debounce.sv
module lane_debounce #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } dbc_t;

    dbc_t d, q;

    always_comb begin
        d = q;
        if (din == q.lvl) begin
            d.cnt = '0;
        end else if (q.cnt == LAST) begin
            d.lvl = din;
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    assign dout = q.lvl;
endmodule

// File: rtl/race_fsm.sv
module race_fsm
    import race_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] db,
    output race_st_e         st_o,
    output logic             tie_o
);
    fsm_regs_t        d, q;
    logic [LANES-1:0] hit;

    always_comb begin
        d     = q;
        d.tie = 1'b0;
        hit   = q.arm & db;
        for (int i = 0; i < LANES; i++) begin
            if (!db[i]) d.arm[i] = 1'b1;
        end
        if (q.st == ST_IDLE && hit != '0) begin
            for (int i = LANES - 1; i >= 0; i--) begin
                if (hit[i]) d.st = race_st_e'(i + 1);
            end
            d.tie = ($countones(hit) > 1);
        end
        if (rst) begin
            d.st  = ST_IDLE;
            d.arm = '0;
            d.tie = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    assign st_o  = q.st;
    assign tie_o = q.tie;

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (q.st == ST_IDLE && !q.tie));

    // R4
    hold_winner_chk: assert property (@(posedge clk) disable iff (rst)
        (q.st != ST_IDLE) |=> $stable(q.st));

    // R7
    tie_single_chk: assert property (@(posedge clk) disable iff (rst)
        q.tie |=> !q.tie);

    // R6
    tie_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        q.tie |-> (q.st == ST_L1 || q.st == ST_L2));

    // R9
    unarmed_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_IDLE && (db & q.arm) == '0) |=> q.st == ST_IDLE);
endmodule

// File: rtl/lane_first_latch.sv
module lane_first_latch
    import race_pkg::*;
#(
    parameter int SYNC_STAGES     = 2,
    parameter int DEBOUNCE_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] btn_raw,
    output logic [LANES-1:0] lane_won,
    output logic [CODE_W-1:0] win_code,
    output logic             win_valid,
    output logic             tie_pulse
);
    logic [LANES-1:0] btn_s;
    logic [LANES-1:0] btn_db;
    race_st_e         st;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .din  (btn_raw[g]),
            .dout (btn_s[g])
        );
        lane_debounce #(.CYCLES(DEBOUNCE_CYCLES)) u_db (
            .clk  (clk),
            .din  (btn_s[g]),
            .dout (btn_db[g])
        );
    end

    race_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .db    (btn_db),
        .st_o  (st),
        .tie_o (tie_pulse)
    );

    always_comb begin
        win_code  = st;
        win_valid = (st != ST_IDLE);
        for (int i = 0; i < LANES; i++) begin
            lane_won[i] = (st == race_st_e'(i + 1));
        end
    end

    // R2
    onehot_out_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lane_won) && (win_valid == (lane_won != '0)));
endmodule

// File: tb/lane_first_latch_tb_top.sv
`timescale 1ns/100ps
module lane_first_latch_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] btn_raw = 3'b000;
    logic [2:0] lane_won;
    logic [1:0] win_code;
    logic       win_valid;
    logic       tie_pulse;
    int checks   = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    lane_first_latch dut_i (
        .clk       (clk),
        .rst       (rst),
        .btn_raw   (btn_raw),
        .lane_won  (lane_won),
        .win_code  (win_code),
        .win_valid (win_valid),
        .tie_pulse (tie_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_out(input string req, input logic [1:0] code, input logic tie);
        logic [2:0] oh;
        oh = (code == 2'b00) ? 3'b000 : 3'(1 << (code - 1));
        chk({req, " code"}, 32'(win_code), 32'(code));
        chk({req, " onehot"}, 32'(lane_won), 32'(oh));
        chk({req, " valid"}, 32'(win_valid), 32'(code != 2'b00));
        chk({req, " tie"}, 32'(tie_pulse), 32'(tie));
    endtask

    task automatic restart();
        @(negedge clk);
        btn_raw = 3'b000;
        clks(10);
        rst = 1'b1;
        clks(2);
        rst = 1'b0;
        clks(2);
    endtask

    // R1: reset state
    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        clks(12);
        chk_out("R1 in reset", 2'b00, 1'b0);
        rst = 1'b0;
        clks(3);
        chk_out("R1 after reset idle R3", 2'b00, 1'b0);
    endtask

    // R3, R2: single lane win with exact latency
    task automatic t_single(input int lane);
        restart();
        btn_raw[lane-1] = 1'b1;
        clks(6);
        chk_out("R3 not yet at 6", 2'b00, 1'b0);
        clks(1);
        chk_out("R3 R2 win at 7", 2'(lane), 1'b0);
        btn_raw = 3'b000;
        clks(10);
    endtask

    // R4: presses after a win are ignored; then R1 clears it
    task automatic t_ignore();
        restart();
        btn_raw = 3'b001;
        clks(7);
        chk_out("R4 lane1 won", 2'b01, 1'b0);
        btn_raw = 3'b110;
        clks(10);
        chk_out("R4 others pressed", 2'b01, 1'b0);
        btn_raw = 3'b000;
        clks(10);
        btn_raw = 3'b001;
        clks(10);
        chk_out("R4 winner repressed", 2'b01, 1'b0);
        btn_raw = 3'b000;
        clks(10);
        rst = 1'b1;
        clks(1);
        chk_out("R1 reset clears winner", 2'b00, 1'b0);
        rst = 1'b0;
        clks(2);
    endtask

    // R6, R7: simultaneous presses
    task automatic t_tie(input logic [2:0] mask, input logic [1:0] code);
        restart();
        btn_raw = mask;
        clks(7);
        chk_out("R6 R7 tie resolved", code, 1'b1);
        clks(1);
        chk_out("R7 tie pulse gone", code, 1'b0);
        btn_raw = 3'b000;
        clks(10);
    endtask

    // R8: short bounces are not presses
    task automatic t_bounce();
        restart();
        for (int k = 0; k < 4; k++) begin
            btn_raw[2] = 1'b1;
            clks(3);
            btn_raw[2] = 1'b0;
            clks(2);
        end
        clks(12);
        chk_out("R8 bounce ignored", 2'b00, 1'b0);
        btn_raw[2] = 1'b1;
        clks(7);
        chk_out("R8 clean press after bounce", 2'b11, 1'b0);
        btn_raw = 3'b000;
        clks(10);
    endtask

    // R5, R9: reset on the press edge; held button then cannot win
    task automatic t_reset_prio();
        restart();
        btn_raw[1] = 1'b1;
        clks(6);
        rst = 1'b1;
        clks(1);
        chk_out("R5 reset beats press", 2'b00, 1'b0);
        rst = 1'b0;
        clks(20);
        chk_out("R9 held button no win", 2'b00, 1'b0);
        btn_raw[1] = 1'b0;
        clks(10);
        chk_out("R9 release no win", 2'b00, 1'b0);
        btn_raw[1] = 1'b1;
        clks(7);
        chk_out("R9 repress wins", 2'b10, 1'b0);
        btn_raw = 3'b000;
        clks(10);
    endtask

    initial begin
        t_reset();
        t_single(1);
        t_single(2);
        t_single(3);
        t_ignore();
        t_tie(3'b110, 2'b10);
        t_tie(3'b111, 2'b01);
        t_tie(3'b101, 2'b01);
        t_bounce();
        t_reset_prio();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog all-R act=running exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule